// File: doc/BRIEF.md
# Johnson Decade Counter with Seven-Segment Drive

This block counts decimal digits in a five-stage Johnson ring and drives one seven-segment digit from that ring. All logic runs on a single system clock, `clk`. The two counting inputs, `cnt_clk_i` and `cnt_inh_i`, are ordinary data inputs that the block samples on every rising edge of `clk`.

The count advances once in either of two cases:
- `cnt_clk_i` shows a rising edge while `cnt_inh_i` is low.
- `cnt_inh_i` shows a falling edge while `cnt_clk_i` is high.

The second case lets the inhibit line act as a count clock of the opposite polarity.

The ring corrects itself. From any of the 22 five-bit codes outside the ten legal ones, it returns to digit 0 at the next count event.

The seven segment outputs are active high and can be blanked with the display-enable input. The carry output and an ungated copy of segment c stay live while the segments are blanked. This supports dividers and multi-digit chains. The carry output goes high on the wrap from 9 to 0, so it can feed the `cnt_clk_i` input of the next decade. The display-enable input is also passed through as an output, so a chain can pass the enable along.

Top module: `johnson_seg_counter`

## Requirements
- R1: Each count event moves the displayed digit from n to (n+1) mod 10, so the digit runs through ten distinct states and wraps from 9 to 0.
- R2: When `rst` is high at a rising edge of `clk`, the count becomes 0 at that edge. This holds even if a count event is present at the same edge.
- R3: A rising edge of `cnt_clk_i` with `cnt_inh_i` low advances the count by one.
  - The edge is seen as a low sample followed by a high sample, each taken at a rising edge of `clk`.
  - The new digit appears at the outputs just after the edge that takes the first high sample.
- R4: While `cnt_inh_i` stays high, edges on `cnt_clk_i` leave the count unchanged.
- R5: A falling edge of `cnt_inh_i` while `cnt_clk_i` is high advances the count by one. The same falling edge with `cnt_clk_i` low does nothing. A falling edge of `cnt_clk_i` never counts.
- R6: If the ring holds any of the 22 illegal five-bit codes, the next count event shows digit 0, and the event after it shows digit 1.
- R7: `carry_o` is high for digits 0 to 4 and low for digits 5 to 9, so it rises on the wrap from 9 to 0.
- R8: While `disp_en_i` is low, `seg_o` is all zeros. While it is high, `seg_o` shows the current digit.
- R9: `carry_o` and `seg_c_raw_o` do not depend on `disp_en_i`. `seg_c_raw_o` equals segment c of the current digit's pattern.
- R10: `disp_en_o` follows `disp_en_i`.
- R11: Segment patterns use `seg_o` bit 0 = a up to bit 6 = g. Digits 6 and 9 are drawn with tails.

  | Digit | Pattern |
  |---|---|
  | 0 | 0x3F |
  | 1 | 0x06 |
  | 2 | 0x5B |
  | 3 | 0x4F |
  | 4 | 0x66 |
  | 5 | 0x6D |
  | 6 | 0x7D |
  | 7 | 0x07 |
  | 8 | 0x7F |
  | 9 | 0x6F |

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset to digit 0 |
| cnt_clk_i | input | 1 | Count input; its rising edge advances the count |
| cnt_inh_i | input | 1 | Count inhibit; its falling edge counts while `cnt_clk_i` is high |
| disp_en_i | input | 1 | Segment enable; low blanks `seg_o` |
| seg_o | output | 7 | Gated segments, bit 0 = a up to bit 6 = g |
| carry_o | output | 1 | Decade carry, high for digits 0 to 4 |
| disp_en_o | output | 1 | Copy of `disp_en_i` for the next digit |
| seg_c_raw_o | output | 1 | Segment c of the current digit, never blanked |

## Verification
The hardest behaviour to reach is recovery from an illegal ring code. Reset and counting only ever produce legal codes, so no sequence on the ports can enter the other 22. The bench therefore overrides the ring register with each illegal code in turn and releases it. It then issues two count events and expects digit 0 and then digit 1. The inhibit-as-clock path is reached by raising `cnt_clk_i` while inhibit is high, then dropping inhibit. That order is also swapped to confirm that no count occurs when `cnt_clk_i` is low.

// File: rtl/jsc_pkg.sv
package jsc_pkg;

  localparam int SEG_W = 7;
  typedef logic [SEG_W-1:0] seg_t;

  // Bit 0 = a ... bit 6 = g; 6 and 9 carry their tails.
  function automatic seg_t digit_glyph(input int unsigned d);
    seg_t g;
    case (d)
      0: g = 7'h3F;
      1: g = 7'h06;
      2: g = 7'h5B;
      3: g = 7'h4F;
      4: g = 7'h66;
      5: g = 7'h6D;
      6: g = 7'h7D;
      7: g = 7'h07;
      8: g = 7'h7F;
      9: g = 7'h6F;
      default: g = '0;
    endcase
    return g;
  endfunction

endpackage

// File: rtl/jsc_advance_detect.sv
module jsc_advance_detect (
  input  logic clk,
  input  logic cnt_clk_i,
  input  logic cnt_inh_i,
  output logic advance_o
);

  logic clk_q;
  logic inh_q;

  // Previous samples track the inputs every cycle, including during reset,
  // so a level held through reset never looks like an edge afterwards.
  always_ff @(posedge clk) begin
    clk_q <= cnt_clk_i;
    inh_q <= cnt_inh_i;
  end

  logic rise_clk_path;
  logic fall_inh_path;

  assign rise_clk_path = cnt_clk_i & ~clk_q & ~cnt_inh_i;
  assign fall_inh_path = cnt_clk_i & inh_q & ~cnt_inh_i;
  assign advance_o     = rise_clk_path | fall_inh_path;

endmodule

// File: rtl/jsc_ring.sv
module jsc_ring #(
  parameter int STAGES = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              advance_i,
  output logic [STAGES-1:0] state_o
);

  localparam int PAIRS = STAGES - 1;

  logic [STAGES-1:0] state_q;
  logic [STAGES-1:0] state_d;
  logic [PAIRS-1:0]  flips;
  logic              legal;

  // A legal Johnson code has at most one boundary between ones and zeros.
  for (genvar i = 0; i < PAIRS; i++) begin : g_pair
    assign flips[i] = state_q[i] ^ state_q[i+1];
  end

  assign legal = ((flips & (flips - PAIRS'(1))) == '0);

  always_comb begin
    state_d = state_q;
    if (advance_i) begin
      if (legal) state_d = {state_q[STAGES-2:0], ~state_q[STAGES-1]};
      else       state_d = '0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) state_q <= '0;
    else     state_q <= state_d;
  end

  assign state_o = state_q;

endmodule

// File: rtl/jsc_decode.sv
module jsc_decode
  import jsc_pkg::*;
#(
  parameter int STAGES = 5
) (
  input  logic [STAGES-1:0] state_i,
  input  logic              disp_en_i,
  output seg_t              seg_o,
  output logic              seg_c_raw_o,
  output logic              carry_o
);

  localparam int COUNT_LEN = 2 * STAGES;

  logic [COUNT_LEN-1:0] hot;

  // Each count is identified by one pair of stage bits.
  assign hot[0]      = ~state_i[0] & ~state_i[STAGES-1];
  assign hot[STAGES] =  state_i[0] &  state_i[STAGES-1];
  for (genvar k = 1; k < STAGES; k++) begin : g_hot
    assign hot[k]          =  state_i[k-1] & ~state_i[k];
    assign hot[STAGES + k] = ~state_i[k-1] &  state_i[k];
  end

  seg_t raw;
  always_comb begin
    raw = '0;
    for (int k = 0; k < COUNT_LEN; k++) begin
      if (hot[k]) raw = raw | digit_glyph(k);
    end
  end

  assign seg_o       = disp_en_i ? raw : '0;
  assign seg_c_raw_o = raw[2];
  assign carry_o     = ~state_i[STAGES-1];

endmodule

// File: rtl/johnson_seg_counter.sv
module johnson_seg_counter
  import jsc_pkg::*;
#(
  parameter int STAGES = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cnt_clk_i,
  input  logic             cnt_inh_i,
  input  logic             disp_en_i,
  output logic [SEG_W-1:0] seg_o,
  output logic             carry_o,
  output logic             disp_en_o,
  output logic             seg_c_raw_o
);

  logic              advance;
  logic [STAGES-1:0] ring_state;

  jsc_advance_detect u_edge (
    .clk       (clk),
    .cnt_clk_i (cnt_clk_i),
    .cnt_inh_i (cnt_inh_i),
    .advance_o (advance)
  );

  jsc_ring #(.STAGES(STAGES)) u_ring (
    .clk       (clk),
    .rst       (rst),
    .advance_i (advance),
    .state_o   (ring_state)
  );

  jsc_decode #(.STAGES(STAGES)) u_dec (
    .state_i     (ring_state),
    .disp_en_i   (disp_en_i),
    .seg_o       (seg_o),
    .seg_c_raw_o (seg_c_raw_o),
    .carry_o     (carry_o)
  );

  assign disp_en_o = disp_en_i;

endmodule

// File: rtl/jsc_checker.sv
module jsc_checker (
  input logic       clk,
  input logic       rst,
  input logic       cnt_inh_i,
  input logic       disp_en_i,
  input logic [6:0] seg_o,
  input logic       carry_o,
  input logic       seg_c_raw_o
);

  // The cycle after reset shows digit 0.
  assert_reset_zero_R2: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (carry_o && seg_c_raw_o));

  // Inhibit held high over two samples leaves the count unchanged.
  assert_inhibit_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (cnt_inh_i && $past(cnt_inh_i) && !$past(rst)) |=>
      ($stable(carry_o) && $stable(seg_c_raw_o)));

  assert_blank_R8: assert property (@(posedge clk) disable iff (rst)
    !disp_en_i |-> (seg_o == 7'h00));

  assert_c_match_R9: assert property (@(posedge clk) disable iff (rst)
    disp_en_i |-> (seg_o[2] == seg_c_raw_o));

  assert_lit_R11: assert property (@(posedge clk) disable iff (rst)
    disp_en_i |-> (seg_o != 7'h00));

endmodule

bind johnson_seg_counter jsc_checker u_chk (
  .clk         (clk),
  .rst         (rst),
  .cnt_inh_i   (cnt_inh_i),
  .disp_en_i   (disp_en_i),
  .seg_o       (seg_o),
  .carry_o     (carry_o),
  .seg_c_raw_o (seg_c_raw_o)
);

// File: tb/johnson_seg_counter_tb.sv
module johnson_seg_counter_tb_top;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cnt_clk = 1'b0;
  logic       cnt_inh = 1'b0;
  logic       disp_en = 1'b1;
  logic [6:0] seg;
  logic       carry;
  logic       disp_en_out;
  logic       seg_c_raw;
  logic [4:0] force_val = '0;

  int compared   = 0;
  int mismatched = 0;
  int exp_d      = 0;
  bit done       = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  johnson_seg_counter dut_i (
    .clk         (clk),
    .rst         (rst),
    .cnt_clk_i   (cnt_clk),
    .cnt_inh_i   (cnt_inh),
    .disp_en_i   (disp_en),
    .seg_o       (seg),
    .carry_o     (carry),
    .disp_en_o   (disp_en_out),
    .seg_c_raw_o (seg_c_raw)
  );

  function automatic logic [6:0] glyph(input int d);
    case (d)
      0: return 7'h3F;
      1: return 7'h06;
      2: return 7'h5B;
      3: return 7'h4F;
      4: return 7'h66;
      5: return 7'h6D;
      6: return 7'h7D;
      7: return 7'h07;
      8: return 7'h7F;
      default: return 7'h6F;
    endcase
  endfunction

  function automatic bit is_legal(input int v);
    for (int k = 0; k < 10; k++) begin
      int code;
      code = (k <= 5) ? ((1 << k) - 1) : (31 & ~((1 << (k - 5)) - 1));
      if (code == v) return 1'b1;
    end
    return 1'b0;
  endfunction

  task automatic check(input string tag);
    logic [10:0] act, exp;
    exp = {disp_en ? glyph(exp_d) : 7'h00, exp_d < 5, glyph(exp_d) >> 2 & 7'h01 ? 1'b1 : 1'b0,
           disp_en};
    act = {seg, carry, seg_c_raw, disp_en_out};
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s digit=%0d actual={seg=%h carry=%b c=%b en=%b} expected={seg=%h carry=%b c=%b en=%b}",
               tag, exp_d, act[10:4], act[3], act[2], act[1], exp[10:4], exp[3], exp[2], exp[1]);
    end
  endtask

  task automatic pulse();
    @(negedge clk); cnt_clk = 1'b1;
    @(negedge clk); cnt_clk = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R2 reset state");

    for (int i = 0; i < 25; i++) begin
      pulse();
      exp_d = (exp_d + 1) % 10;
      check("R1 R3 R7 R11 count sweep");
    end

    disp_en = 1'b0;
    for (int i = 0; i < 10; i++) begin
      pulse();
      exp_d = (exp_d + 1) % 10;
      check("R8 R9 blanked sweep");
    end
    disp_en = 1'b1;
    @(negedge clk);
    check("R10 enable restored");

    cnt_inh = 1'b1;
    for (int i = 0; i < 4; i++) begin
      pulse();
      check("R4 inhibited clock");
    end

    // Clock raised under inhibit, then inhibit falls: one count.
    @(negedge clk); cnt_clk = 1'b1;
    @(negedge clk); check("R4 rise under inhibit");
    cnt_inh = 1'b0;
    @(negedge clk);
    exp_d = (exp_d + 1) % 10;
    check("R5 inhibit fall with clock high");
    cnt_clk = 1'b0;
    @(negedge clk); check("R5 clock fall no count");
    cnt_inh = 1'b1;
    @(negedge clk); cnt_inh = 1'b0;
    @(negedge clk); check("R5 inhibit fall with clock low");

    pulse(); exp_d = (exp_d + 1) % 10;
    @(negedge clk); rst = 1'b1; cnt_clk = 1'b1;
    @(negedge clk); rst = 1'b0;
    exp_d = 0;
    check("R2 reset beats count event");
    cnt_clk = 1'b0;
    @(negedge clk); check("R2 hold after reset");

    for (int v = 0; v < 32; v++) begin
      if (!is_legal(v)) begin
        @(negedge clk);
        force_val = 5'(v);
        force dut_i.u_ring.state_q = force_val;
        #1 release dut_i.u_ring.state_q;
        pulse(); exp_d = 0;
        check("R6 recover to zero");
        pulse(); exp_d = 1;
        check("R6 count after recovery");
      end
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

endmodule